// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives words over a half-duplex synchronous serial link and drives the link's shift clock itself. A programmable divider sets the shift clock rate. The block captures one data bit on the falling edge of each internal clock period, least significant bit first. Each word carries eight bits, or nine when the wide mode is on.

Software runs the block through a small register bus with a write strobe and a read strobe. A single-word enable receives exactly one word and then clears itself. A continuous enable receives words back to back until software clears it, and it overrides the single-word enable when both are set. A completed word lands in a holding register and raises a done flag, which can drive an interrupt line. Reading the data register clears the flag. If a new word completes while the previous one is still unread, the new word is dropped. An overrun flag is then set and reception halts. Writing the control register with the continuous enable at 0 clears the overrun.

Top module: `sync_master_rx`

## Requirements
- R1: The shift clock runs only when CTRL (address 0) has port enable (bit 0), synchronous select (bit 1) and clock-master select (bit 2) all at 1, and at least one receive enable is set. Otherwise `sclk_o` holds its idle level and no word completes.
- R2: While the internal clock is high the bench drives `sdat_i`, and the block samples it as the internal clock falls. Bits fill the word from bit 0 upward, and the data register (address 2) returns bits 7:0.
- R3: With single-word enable (CTRL bit 4) set and continuous enable clear, exactly one word is received. CTRL bit 4 then reads back as 0 and the clock stays idle.
- R4: With continuous enable (CTRL bit 5) set, words are received back to back until bit 5 is cleared, after which the clock stays idle.
- R5: When CTRL bits 4 and 5 are both set, reception is continuous, and bit 4 is not cleared when a word completes.
- R6: With wide mode (CTRL bit 3) set, a word is nine bits, and the ninth bit reads in STATUS (address 1) bit 0. In eight-bit mode STATUS bit 0 reads 0.
- R7: A completed word sets STATUS bit 2. A read of address 2 clears it. `irq_o` equals that flag ANDed with IRQ-enable (address 5, bit 0).
- R8: A word that completes while STATUS bit 2 is still set is discarded. STATUS bit 1 (overrun) then sets, the held data is kept, and the clock stops. A CTRL write with bit 5 at 0 clears the overrun.
- R9: CTRL bit 6 inverts the clock output, so that the idle level of `sclk_o` is 1 when bit 6 is 1 and 0 when it is 0.
- R10: Each clock half-period lasts D+1 cycles. With CTRL bit 7 at 1, D is {DIVHI (address 4), DIVLO (address 3)}. With bit 7 at 0, D is DIVLO alone and DIVHI is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Register write data |
| rdata | output | DW | Register read data, valid while `rd_en` is high |
| sdat_i | input | 1 | Serial data from the link |
| sclk_o | output | 1 | Generated shift clock |
| irq_o | output | 1 | Receive-complete interrupt |

## Verification
The bench goes after the precedence and release rules of the two enables. A design that let the single-word enable win, or that cleared it during continuous reception, would stop after one word in the both-set case. The overrun case leaves one word unread while a second word arrives. A design that overwrote the holding register, or kept clocking, would return the wrong data or show clock toggles during the halt. The divider is measured with the high reload byte both used and ignored, including a value above 255. Nine-bit capture and clock polarity are checked against idle levels and readback in a table of single-word receptions.

// File: rtl/srx_pkg.sv
// Shared definitions for the synchronous master receiver: register
// addresses, control-byte layout and status bit positions.
// Assumes a register bus of at least eight bits.
package srx_pkg;

    localparam int A_CTRL  = 0;
    localparam int A_STAT  = 1;
    localparam int A_DATA  = 2;
    localparam int A_DIVLO = 3;
    localparam int A_DIVHI = 4;
    localparam int A_IEN   = 5;

    localparam int CTRL_STREAM_BIT = 5;

    localparam int STAT_NINTH = 0;
    localparam int STAT_OVR   = 1;
    localparam int STAT_DONE  = 2;

    typedef struct packed {
        logic div16;
        logic ck_inv;
        logic stream;
        logic one_shot;
        logic wide9;
        logic master_sel;
        logic sync_sel;
        logic port_en;
    } ctrl_t;

endpackage

// File: rtl/srx_divider.sv
// Rate divider: produces a one-cycle tick every LIMIT+1 cycles while
// enabled, and restarts from zero whenever it is disabled.
// Assumes the limit is held steady during a reception.
module srx_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         tick
);

    logic [W-1:0] cnt_q;

    assign tick = en && (cnt_q == limit);

    // count up to the limit and wrap, held at zero while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/srx_shifter.sv
// Bit engine: toggles the internal shift clock on each tick and captures
// the data line when the clock falls, filling the word from bit 0 up.
// Flags the last capture of a word with a one-cycle done pulse.
// Assumes run drops to abort a partial word; the clock then idles low.
module srx_shifter #(
    parameter int DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        tick,
    input  logic        wide9,
    input  logic        sdat_i,
    output logic        ck_o,
    output logic        done_o,
    output logic [DW:0] word_o
);

    localparam int IW = $clog2(DW + 1);

    logic [IW-1:0] idx_q;
    logic [IW-1:0] last_idx;
    logic [DW:0]   sh_q;
    logic          ck_q;
    logic          fall;

    assign last_idx = wide9 ? IW'(DW) : IW'(DW - 1);
    assign fall     = run && tick && ck_q;
    assign done_o   = fall && (idx_q == last_idx);
    assign ck_o     = ck_q;

    // clock phase and bit position, reset whenever reception is off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_q  <= 1'b0;
            idx_q <= '0;
        end else if (!run) begin
            ck_q  <= 1'b0;
            idx_q <= '0;
        end else if (tick) begin
            ck_q <= ~ck_q;
            if (ck_q) begin
                idx_q <= (idx_q == last_idx) ? '0 : idx_q + 1'b1;
            end
        end
    end

    // capture the data line into the current bit slot on a falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (fall) begin
            sh_q[idx_q] <= sdat_i;
        end
    end

    // the completed word includes the bit being captured this cycle
    always_comb begin
        word_o         = sh_q;
        word_o[idx_q]  = sdat_i;
        if (!wide9) begin
            word_o[DW] = 1'b0;
        end
    end

endmodule

// File: rtl/srx_regs.sv
// Register file: control, divider reload bytes, interrupt enable, the
// receive holding register and its done/overrun/ninth-bit status.
// Assumes DW >= 8 so the control byte fits one bus word.
module srx_regs
    import srx_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          word_done,
    input  logic [DW:0]   word_in,
    output ctrl_t         ctrl_o,
    output logic [2*DW-1:0] divisor_o,
    output logic          ovr_o,
    output logic          irq_o
);

    ctrl_t         ctrl_q;
    logic [DW-1:0] div_lo_q;
    logic [DW-1:0] div_hi_q;
    logic [DW-1:0] hold_q;
    logic          ien_q;
    logic          flag_q;
    logic          ovr_q;
    logic          nth_q;
    logic          ctrl_wr;
    logic          data_rd;
    logic          flag_live;
    logic          accept;

    assign ctrl_wr   = wr_en && (addr == AW'(A_CTRL));
    assign data_rd   = rd_en && (addr == AW'(A_DATA));
    assign flag_live = flag_q && !data_rd;
    assign accept    = word_done && !flag_live;

    // control byte: software write wins, else single mode self-clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(wdata[7:0]);
        end else if (word_done && ctrl_q.one_shot && !ctrl_q.stream) begin
            ctrl_q.one_shot <= 1'b0;
        end
    end

    // divider reload bytes and interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lo_q <= '0;
            div_hi_q <= '0;
            ien_q    <= 1'b0;
        end else if (wr_en) begin
            if (addr == AW'(A_DIVLO)) div_lo_q <= wdata;
            if (addr == AW'(A_DIVHI)) div_hi_q <= wdata;
            if (addr == AW'(A_IEN))   ien_q    <= wdata[0];
        end
    end

    // holding register, ninth bit and done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            nth_q  <= 1'b0;
            flag_q <= 1'b0;
        end else if (accept) begin
            hold_q <= word_in[DW-1:0];
            nth_q  <= word_in[DW];
            flag_q <= 1'b1;
        end else if (data_rd) begin
            flag_q <= 1'b0;
        end
    end

    // overrun: set by an unread collision, cleared by dropping continuous mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (ctrl_wr && !wdata[CTRL_STREAM_BIT]) begin
            ovr_q <= 1'b0;
        end else if (word_done && flag_live) begin
            ovr_q <= 1'b1;
        end
    end

    // read mux, zero when no read is strobed
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                AW'(A_CTRL):  rdata = DW'(ctrl_q);
                AW'(A_STAT): begin
                    rdata[STAT_NINTH] = nth_q;
                    rdata[STAT_OVR]   = ovr_q;
                    rdata[STAT_DONE]  = flag_q;
                end
                AW'(A_DATA):  rdata = hold_q;
                AW'(A_DIVLO): rdata = div_lo_q;
                AW'(A_DIVHI): rdata = div_hi_q;
                AW'(A_IEN):   rdata = DW'(ien_q);
                default:      rdata = '0;
            endcase
        end
    end

    assign ctrl_o    = ctrl_q;
    assign divisor_o = ctrl_q.div16 ? {div_hi_q, div_lo_q} : {{DW{1'b0}}, div_lo_q};
    assign ovr_o     = ovr_q;
    assign irq_o     = flag_q && ien_q;

endmodule

// File: rtl/sync_master_rx.sv
// Synchronous master serial receiver top: joins the register file, the
// rate divider and the bit engine, and gates reception on the enables.
// Assumes sdat_i is already synchronous to clk.
module sync_master_rx
    import srx_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          sdat_i,
    output logic          sclk_o,
    output logic          irq_o
);

    localparam int DIVW = 2 * DW;

    ctrl_t           ctrl;
    logic [DIVW-1:0] divisor;
    logic            ovr;
    logic            run;
    logic            tick;
    logic            ck;
    logic            word_done;
    logic [DW:0]     word;

    srx_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .word_done (word_done),
        .word_in   (word),
        .ctrl_o    (ctrl),
        .divisor_o (divisor),
        .ovr_o     (ovr),
        .irq_o     (irq_o)
    );

    // reception runs only with the port configured as clock master
    assign run = ctrl.port_en && ctrl.sync_sel && ctrl.master_sel
              && (ctrl.stream || ctrl.one_shot) && !ovr;

    srx_divider #(.W(DIVW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run),
        .limit (divisor),
        .tick  (tick)
    );

    srx_shifter #(.DW(DW)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick   (tick),
        .wide9  (ctrl.wide9),
        .sdat_i (sdat_i),
        .ck_o   (ck),
        .done_o (word_done),
        .word_o (word)
    );

    assign sclk_o = ck ^ ctrl.ck_inv;

endmodule

// File: rtl/srx_checker.sv
// Property checker for the synchronous master receiver, bound to the top.
module srx_checker
    import srx_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic          wr_stream_bit,
    input logic          sclk_o,
    input logic          run,
    input logic          ck,
    input logic          word_done,
    input ctrl_t         ctrl,
    input logic          flag,
    input logic          ovr,
    input logic [DW-1:0] hold
);

    logic ctrl_wr;
    assign ctrl_wr = wr_en && (addr == AW'(A_CTRL));

    p_gate_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.port_en && ctrl.sync_sel && ctrl.master_sel) |=> !ck);

    p_oneshot_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && ctrl.one_shot && !ctrl.stream && !ctrl_wr) |=> !ctrl.one_shot);

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(A_DATA) && !word_done) |=> !flag);

    p_hold_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> $stable(hold));

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !(ctrl_wr && !wr_stream_bit)) |=> ovr);

    p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ctrl_wr) |=> (sclk_o == ctrl.ck_inv));

endmodule

bind sync_master_rx srx_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .addr          (addr),
    .wr_stream_bit (wdata[5]),
    .sclk_o        (sclk_o),
    .run           (run),
    .ck            (ck),
    .word_done     (word_done),
    .ctrl          (ctrl),
    .flag          (u_regs.flag_q),
    .ovr           (ovr),
    .hold          (u_regs.hold_q)
);

// File: tb/sync_master_rx_test.sv
module sync_master_rx_test;

    localparam int DW = 8;
    localparam int AW = 3;

    // {irq enable, clock invert, wide mode, 9-bit data}
    localparam logic [11:0] VEC [6] = '{
        12'h8A5, 12'hC3C, 12'h3C3, 12'hF00, 12'h4FF, 12'hA01
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic          rd_en;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          sdat_i;
    logic          sclk_o;
    logic          irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit inv     = 1'b0;
    bit ended   = 1'b0;

    always #2 clk = ~clk;

    sync_master_rx #(.DW(DW), .AW(AW)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .sdat_i (sdat_i),
        .sclk_o (sclk_o),
        .irq_o  (irq_o)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = AW'(a);
        wdata = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = AW'(a);
        #1 v = int'(rdata);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        addr = '0; wdata = '0; sdat_i = 1'b0; inv = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wr(3, 3);
    endtask

    // drive one bit per internal clock high phase, LSB first
    task automatic drive_word(input int w, input int nb);
        for (int i = 0; i < nb; i++) begin
            do @(negedge clk); while (!(sclk_o ^ inv));
            sdat_i = w[i];
            do @(negedge clk); while (sclk_o ^ inv);
        end
    endtask

    task automatic idle_check(input string tag, input int n);
        int   ch;
        logic prev;
        ch = 0;
        @(negedge clk);
        prev = sclk_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sclk_o !== prev) ch++;
            prev = sclk_o;
        end
        check({tag, " idle level"}, int'(sclk_o), int'(inv));
        check({tag, " no toggles"}, ch, 0);
    endtask

    task automatic measure(output int n);
        logic p;
        @(negedge clk);
        p = sclk_o;
        do @(negedge clk); while (sclk_o == p);
        p = sclk_o;
        n = 0;
        do begin @(negedge clk); n++; end while (sclk_o == p);
    endtask

    task automatic finish_run();
        ended = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int          v;
        int          ctl;
        logic [11:0] vec;

        // reset state
        do_reset();
        rd(0, v); check("reset CTRL", v, 0);
        rd(1, v); check("reset STATUS", v, 0);
        check("reset sclk_o", int'(sclk_o), 0);
        check("reset irq_o", int'(irq_o), 0);

        // table of single-word receptions
        for (int k = 0; k < 6; k++) begin
            vec = VEC[k];
            wr(5, int'(vec[11]));
            ctl = 'h17 | (vec[9] ? 'h08 : 0) | (vec[10] ? 'h40 : 0);
            wr(0, ctl);
            inv = vec[10];
            drive_word(int'(vec[8:0]), vec[9] ? 9 : 8);
            @(negedge clk);
            rd(1, v);
            check("R7 done flag set", (v >> 2) & 1, 1);
            check("R6 ninth bit", v & 1, vec[9] ? int'(vec[8]) : 0);
            check("R7 irq follows enable", int'(irq_o), int'(vec[11]));
            check("R9 idle level after word", int'(sclk_o), int'(vec[10]));
            rd(0, v);
            check("R3 single enable self-clears", (v >> 4) & 1, 0);
            rd(2, v);
            check("R2 data LSB first", v, int'(vec[7:0]));
            rd(1, v);
            check("R7 read clears flag", (v >> 2) & 1, 0);
            check("R7 irq drops", int'(irq_o), 0);
        end
        idle_check("R3 single stops", 20);

        // gating by port, sync and master selects
        do_reset();
        wr(0, 'h26); idle_check("R1 no port enable", 40);
        rd(1, v); check("R1 no word without port enable", v, 0);
        wr(0, 'h25); idle_check("R1 no sync select", 40);
        rd(1, v); check("R1 no word without sync select", v, 0);
        wr(0, 'h23); idle_check("R1 no master select", 40);
        rd(1, v); check("R1 no word without master select", v, 0);

        // polarity with reception off
        do_reset();
        wr(0, 'h47); inv = 1'b1;
        idle_check("R9 inverted idle", 20);

        // continuous reception
        do_reset();
        wr(0, 'h27);
        drive_word('h5A, 8); rd(2, v); check("R4 word 1", v, 'h5A);
        drive_word('h96, 8); rd(2, v); check("R4 word 2", v, 'h96);
        drive_word('h33, 8); rd(2, v); check("R4 word 3", v, 'h33);
        wr(0, 'h07);
        repeat (3) @(negedge clk);
        idle_check("R4 stops when cleared", 30);
        rd(1, v); check("R4 no overrun", (v >> 1) & 1, 0);

        // both enables: continuous governs
        do_reset();
        wr(0, 'h37);
        drive_word('hC1, 8); rd(2, v); check("R5 word 1", v, 'hC1);
        drive_word('h7E, 8); rd(2, v); check("R5 word 2", v, 'h7E);
        rd(0, v); check("R5 single enable kept", (v >> 4) & 1, 1);
        wr(0, 'h07);

        // overrun
        do_reset();
        wr(0, 'h27);
        drive_word('h11, 8);
        drive_word('h22, 8);
        @(negedge clk);
        rd(1, v);
        check("R8 overrun set", (v >> 1) & 1, 1);
        check("R8 flag still set", (v >> 2) & 1, 1);
        repeat (2) @(negedge clk);
        idle_check("R8 halted", 30);
        wr(0, 'h07);
        rd(1, v); check("R8 overrun cleared", (v >> 1) & 1, 0);
        rd(2, v); check("R8 first word kept", v, 'h11);

        // divider
        do_reset();
        wr(0, 'h27); measure(v); check("R10 8-bit D=3", v, 4);
        do_reset();
        wr(3, 2); wr(4, 1); wr(0, 'h27); measure(v); check("R10 high byte ignored", v, 3);
        do_reset();
        wr(3, 5); wr(4, 0); wr(0, 'hA7); measure(v); check("R10 16-bit D=5", v, 6);
        do_reset();
        wr(3, 0); wr(4, 1); wr(0, 'hA7); measure(v); check("R10 16-bit D=256", v, 257);

        finish_run();
    end

endmodule